// File: doc/BRIEF.md
# Loop-Up Code Detector with Supervision Timer

This block watches one recovered receive bit stream for a maintenance request from the far end. The request opens with a loop-up code: a maximal-length pseudorandom sequence of period 127 built from the recurrence b(n) = b(n-7) xor b(n-6). The block tracks the sequence with a seven-bit history and predicts each new bit from it. Once the code has matched without a break for a set run of bits, the block raises a sticky "seen" flag and starts a supervision timer. If the far end stops sending the code before the timer runs out, the block declares the loopback active. The loopback ends when the complemented sequence (the loop-down code) has matched for the same run length. If the timer runs out first, the block raises a sticky timeout flag and ignores the line until the host clears it.

Bits arrive as a valid-qualified serial stream with no ready signal. The block accepts one bit on every cycle where `bit_vld` is high and cannot apply back-pressure. The source may hold `bit_vld` low for any number of cycles, and those cycles have no effect at all. Software first waits for `lup_seen`. It then reads `sup_expired`, and places channels into loopback only if that flag is clear. It uses `host_clr` to start a fresh search. The loopback switching itself, channel selection and interrupt gathering sit outside this block.

Top module: `lu_detector`

## Requirements
- R1: After `rst_n` is released, `lup_seen`, `loop_on` and `sup_expired` are all 0.
- R2: A bit counts as a loop-up match only when all three of these hold: it equals the xor of the bits received 7 and 6 valid bits earlier, at least 7 valid bits have arrived since reset, and those last 7 bits are not all zero. Detection happens on exactly the HOLD_BITS-th consecutive match; a single mismatch restarts the count. From reset, a clean sequence is therefore detected on its 39th bit (with HOLD_BITS = 32).
- R3: Detection sets `lup_seen`, which stays at 1 until `host_clr` or reset. Detection also restarts the supervision timer and leaves `loop_on` at 0.
- R4: If TMO_BITS further valid bits after detection all still match the loop-up code, `sup_expired` rises on the last of them. It stays set, `loop_on` stays 0, and the line is ignored until `host_clr` or reset.
- R5: After detection, the first valid bit that does not match the loop-up code, arriving before the timer expires, sets `loop_on`.
- R6: While the loopback is active, `loop_on` clears on the HOLD_BITS-th consecutive match of the loop-down code. A loop-down match is a bit that differs from the predicted bit while the last 7 bits are not all ones. The block then searches again, and `lup_seen` stays at 1.
- R7: A cycle with `host_clr` high returns the block to search, clears all three flags on the next edge, and discards any partial match run. This takes priority over a bit arriving in the same cycle.
- R8: A cycle with `bit_vld` low changes no flag, no match run and no timer count, whatever `bit_dat` carries.
- R9: An all-zero stream never produces detection, and an all-ones stream never ends an active loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `bit_dat` on this cycle |
| bit_dat | input | 1 | Received serial bit |
| host_clr | input | 1 | Host restart of the search; clears all flags |
| lup_seen | output | 1 | Sticky: loop-up code held for the full run |
| loop_on | output | 1 | Loopback request is active |
| sup_expired | output | 1 | Sticky: supervision timer ran out after detection |

## Verification
The hardest state to reach is the exact end of a loopback. The loop-down code has to be fed over a history that still holds loop-up bits, and the seventh bit after the switch always breaks the run. That pushes the release out to the 39th complemented bit. The bench keeps one reference sequence generator running throughout and only inverts its output, so this switchover is reproducible in every phase. A short timer parameter lets the timeout edge be hit to the exact bit, both the bit before expiry and the expiring bit.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_ARMED   = 2'd1,
    ST_LOOPED  = 2'd2,
    ST_EXPIRED = 2'd3
  } lu_state_e;
endpackage

// File: rtl/lu_prbs_predictor.sv
// Predicts each incoming bit from the recurrence b(n)=b(n-ORDER) xor b(n-TAP)
// and reports agreement (loop-up) or complement agreement (loop-down).
module lu_prbs_predictor #(
  parameter int ORDER = 7,
  parameter int TAP   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_dat,
  output logic up_hit,
  output logic dn_hit
);
  localparam int FW = $clog2(ORDER + 1);
  localparam logic [FW-1:0] FULL = FW'(ORDER);

  logic [ORDER-1:0] hist_q;
  logic [FW-1:0]    fill_q;
  logic             pred;
  logic             primed;
  logic             hist_zero;
  logic             hist_ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      hist_q <= {hist_q[ORDER-2:0], bit_dat};
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  always_comb begin
    pred      = hist_q[ORDER-1] ^ hist_q[TAP-1];
    primed    = (fill_q == FULL);
    hist_zero = (hist_q == '0);
    hist_ones = &hist_q;
    up_hit    = bit_vld & primed & ~hist_zero & (bit_dat == pred);
    dn_hit    = bit_vld & primed & ~hist_ones & (bit_dat != pred);
  end
endmodule

// File: rtl/lu_run_counter.sv
// Counts consecutive matching bits; reached fires on the LIMIT-th one.
module lu_run_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic hit,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!hit)               cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reached = step & hit & (cnt_q == LAST);
endmodule

// File: rtl/lu_sup_timer.sv
// Bit-clock supervision timer; last fires on the LIMIT-th counted bit.
module lu_sup_timer #(
  parameter int LIMIT = 8192000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)              cnt_q <= '0;
    else if (step && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last = step & (cnt_q == LAST);
endmodule

// File: rtl/lu_detector.sv
module lu_detector
  import lu_pkg::*;
#(
  parameter int HOLD_BITS  = 32,
  parameter int TMO_BITS   = 8192000,
  parameter int PRBS_ORDER = 7,
  parameter int PRBS_TAP   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_dat,
  input  logic host_clr,
  output logic lup_seen,
  output logic loop_on,
  output logic sup_expired
);
  lu_state_e state_q, state_d;
  logic seen_q, seen_d, loop_q, loop_d, tmo_q, tmo_d;
  logic up_hit, dn_hit;
  logic run_hit, run_step, run_clr, run_reached;
  logic tmr_step, tmr_clr, tmr_last;

  lu_prbs_predictor #(.ORDER(PRBS_ORDER), .TAP(PRBS_TAP)) u_pred (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .up_hit(up_hit), .dn_hit(dn_hit)
  );

  assign run_hit  = (state_q == ST_LOOPED) ? dn_hit : up_hit;
  assign run_step = bit_vld & ((state_q == ST_SEARCH) | (state_q == ST_LOOPED));
  assign run_clr  = host_clr | (state_d != state_q);

  lu_run_counter #(.LIMIT(HOLD_BITS)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .step(run_step),
    .hit(run_hit), .reached(run_reached)
  );

  assign tmr_step = bit_vld & (state_q == ST_ARMED);
  assign tmr_clr  = host_clr | (state_q != ST_ARMED);

  lu_sup_timer #(.LIMIT(TMO_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .step(tmr_step), .last(tmr_last)
  );

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    loop_d  = loop_q;
    tmo_d   = tmo_q;
    if (host_clr) begin
      state_d = ST_SEARCH;
      seen_d  = 1'b0;
      loop_d  = 1'b0;
      tmo_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_SEARCH: if (run_reached) begin
          state_d = ST_ARMED;
          seen_d  = 1'b1;
        end
        ST_ARMED: begin
          if (bit_vld && !up_hit) begin
            state_d = ST_LOOPED;
            loop_d  = 1'b1;
          end else if (tmr_last) begin
            state_d = ST_EXPIRED;
            tmo_d   = 1'b1;
          end
        end
        ST_LOOPED: if (run_reached) begin
          state_d = ST_SEARCH;
          loop_d  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      seen_q  <= 1'b0;
      loop_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      loop_q  <= loop_d;
      tmo_q   <= tmo_d;
    end
  end

  assign lup_seen    = seen_q;
  assign loop_on     = loop_q;
  assign sup_expired = tmo_q;
endmodule

// File: rtl/lu_detector_chk.sv
module lu_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic host_clr,
  input logic lup_seen,
  input logic loop_on,
  input logic sup_expired
);
  AST_TMO_AFTER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_expired) |-> lup_seen); // R4
  AST_TMO_LOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_expired && loop_on)); // R4
  AST_LOOP_AFTER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_on) |-> lup_seen); // R5
  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lup_seen && !host_clr) |=> lup_seen); // R3
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> (!lup_seen && !loop_on && !sup_expired)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !host_clr) |=> $stable({lup_seen, loop_on, sup_expired})); // R8
endmodule

bind lu_detector lu_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .host_clr(host_clr),
  .lup_seen(lup_seen), .loop_on(loop_on), .sup_expired(sup_expired)
);

// File: tb/test_lu_detector.sv
`timescale 1ns/1ps
module test_lu_detector;
  localparam int HOLD = 32;
  localparam int TMO  = 100;
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1, M_ZERO = 2'd2, M_ONE = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, bit_vld = 1'b0, bit_dat = 1'b0, host_clr = 1'b0;
  logic lup_seen, loop_on, sup_expired;
  int checks = 0, errors = 0, cycles = 0;
  logic [6:0] gen = 7'h5A;

  always #2 clk = ~clk;

  lu_detector #(.HOLD_BITS(HOLD), .TMO_BITS(TMO)) i_lu_detector (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .host_clr(host_clr), .lup_seen(lup_seen), .loop_on(loop_on),
    .sup_expired(sup_expired)
  );

  // {mode[1:0], count[15:0], req[3:0], expect {seen,loop,tmo}}
  localparam logic [24:0] TBL [10] = '{
    {M_UP, 16'd38, 4'd2, 3'b000},  // R2: one bit short
    {M_UP, 16'd1,  4'd3, 3'b100},  // R3: detected on 39th bit
    {M_UP, 16'd99, 4'd4, 3'b100},  // R4: one bit before expiry
    {M_DN, 16'd1,  4'd5, 3'b110},  // R5: code ends in time
    {M_DN, 16'd37, 4'd6, 3'b110},  // R6: still looped
    {M_DN, 16'd1,  4'd6, 3'b100},  // R6: released on 39th complemented bit
    {M_UP, 16'd39, 4'd3, 3'b100},  // R3: second detection
    {M_UP, 16'd99, 4'd4, 3'b100},  // R4
    {M_UP, 16'd1,  4'd4, 3'b101},  // R4: expired
    {M_DN, 16'd40, 4'd4, 3'b101}   // R4: line ignored once expired
  };

  task automatic chk(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {lup_seen, loop_on, sup_expired};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flags got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] mode, input int n);
    for (int i = 0; i < n; i++) begin
      logic o;
      @(negedge clk);
      o = gen[6] ^ gen[5];
      case (mode)
        M_UP:    begin bit_dat = o;  gen = {gen[5:0], o}; end
        M_DN:    begin bit_dat = ~o; gen = {gen[5:0], o}; end
        M_ZERO:  bit_dat = 1'b0;
        default: bit_dat = 1'b1;
      endcase
      bit_vld = 1'b1;
    end
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_dat = i[0] ^ i[2];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_vld = 1'b0; host_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(3'b000, "R1 after reset");
    for (int i = 0; i < 10; i++) begin
      send(TBL[i][24:23], int'(TBL[i][22:7]));
      chk(TBL[i][2:0], $sformatf("R%0d table row %0d", TBL[i][6:3], i));
    end
    // R7: host clear from expired state
    @(negedge clk); host_clr = 1'b1;
    @(negedge clk); host_clr = 1'b0;
    chk(3'b000, "R7 clear");
    send(M_UP, 38);
    chk(3'b000, "R7 run restarted");
    send(M_UP, 1);
    chk(3'b100, "R7 redetect");
    send(M_DN, 1);
    chk(3'b110, "R5 loop on");
    // R9: all ones never releases the loopback
    send(M_ONE, 80);
    chk(3'b110, "R9 ones keep loop");
    do_reset();
    chk(3'b000, "R1 second reset");
    // R9: all zeros never detect
    send(M_ZERO, 200);
    chk(3'b000, "R9 zeros");
    // R8: idle cycles do not advance the run
    do_reset();
    send(M_UP, 38);
    idle(300);
    chk(3'b000, "R8 gap no effect");
    send(M_UP, 1);
    chk(3'b100, "R8 run held across gap");
    // R8: idle in armed state does not advance the timer
    send(M_UP, 99);
    idle(300);
    chk(3'b100, "R8 timer held");
    send(M_UP, 1);
    chk(3'b101, "R4 expiry after gap");
    // R7: clear wins over a bit in the same cycle
    @(negedge clk); host_clr = 1'b1; bit_vld = 1'b1; bit_dat = 1'b0;
    @(negedge clk); host_clr = 1'b0; bit_vld = 1'b0;
    chk(3'b000, "R7 clear priority");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule